// File: doc/BRIEF.md
# Zero-Overhead Loop Program Sequencer

This block produces the instruction fetch address of a small DSP core once per clock. The core's decoder describes the instruction at the current fetch address with an operation code, a condition flag, an immediate target and, for loop set-up, an iteration count. From these the sequencer picks the next address. The choices are the incremented address, a conditional jump target, a subroutine target, an address popped on return, or the top of the active loop. Jumps, calls and returns all redirect fetch on the very next cycle.

Loops are closed in hardware. A loop set-up operation records three things on three stacks: the loop's first address, its last address and its iteration count. The first address goes on the subroutine return stack. Afterwards the sequencer compares every fetch address with the innermost loop's last address. When they match and the instruction there is sequential, fetch goes back to the loop top, or leaves the loop on its final pass, with no branch instruction and no lost cycle. Depth limits are enforced, and overflow and underflow are reported through sticky flags.

Top module: `zol_sequencer`

## Requirements
- R1: While `rst_n` is low and just after it rises, the fetch address is 0, the return stack is empty, no loop is active and all six overflow/underflow flags are 0.
- R2: Operation code 0 (sequential) with no loop end matched makes the next fetch address the current one plus 1.
- R3: Operation code 1 (jump) makes the next fetch address `target_i` when `cond_i` is 1, and the current address plus 1 when `cond_i` is 0.
- R4: Operation code 2 (call) pushes the current address plus 1 on the return stack and makes the next fetch address `target_i`.
- R5: Operation code 3 (return) pops the return stack, and the popped address becomes the next fetch address.
- R6: Operation code 4 (loop set-up) pushes the current address plus 1 (loop top) on the return stack, `target_i` (loop end) on the loop-end stack and `count_i` on the counter stack. The next fetch address is the current one plus 1, and `loop_active_o` goes to 1.
- R7: A sequential instruction whose address equals the innermost loop end, while that loop's count is above 1, makes the next fetch address the loop top and lowers that count by 1. An instruction with any other operation code at that address takes its own path instead.
- R8: At the loop end with a count of 1 or 0, the return, loop-end and counter stacks are each popped once, and the next fetch address is the loop end plus 1.
- R9: With loops nested, only the innermost loop end is compared, and after the inner loop exits the outer loop continues with its own top and count.
- R10: The return stack holds 16 entries. A push onto a full stack is dropped and sets `ovf_o[0]` until reset, and the call still redirects fetch.
- R11: A return on an empty stack sets `unf_o[0]` until reset and makes the next fetch address the current one plus 1.
- R12: The loop-end and counter stacks hold 4 entries each. A fifth nested loop set-up sets `ovf_o[1]` and `ovf_o[2]` until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| op_i | input | 3 | Decoded operation: 0 sequential, 1 jump, 2 call, 3 return, 4 loop set-up; 5 to 7 act as 0 |
| cond_i | input | 1 | Condition for a jump |
| target_i | input | AW (12) | Jump or call target, or loop end address for loop set-up |
| count_i | input | CW (16) | Iteration count for loop set-up |
| fetch_addr_o | output | AW (12) | Current fetch address |
| pc_stk_empty_o | output | 1 | Return stack holds no entry |
| loop_active_o | output | 1 | At least one loop is open |
| ovf_o | output | 3 | Sticky overflow: bit 0 return stack, bit 1 loop-end stack, bit 2 counter stack |
| unf_o | output | 3 | Sticky underflow, same bit order as `ovf_o` |

## Verification
Every result is due exactly one clock edge after its stimulus. The fetch register, the stack pointers and the sticky flags are all written by that edge from decode inputs held stable during the preceding cycle. The bench changes inputs on the falling edge and samples on the next falling edge, which is the cycle in which a jump, call, return, loop-back or loop exit must show up. Stack status reflects the same edge, so it is read in the same sample. Multi-step behaviour, such as counts running down, nesting or the seventeenth push, is checked one edge at a time with no skipped samples.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_DO   = 3'd4
  } seq_op_e;
endpackage

// File: rtl/zol_stack.sv
// LIFO with top-of-stack rewrite and sticky overflow/underflow flags.
module zol_stack #(
  parameter int W     = 12,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_top,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         ovf,
  output logic         unf
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d, top_ptr;
  logic [IW-1:0] wr_idx, top_idx;
  logic          full;
  logic          ovf_q, ovf_d, unf_q, unf_d;

  assign empty   = (ptr_q == '0);
  assign full    = (ptr_q == PW'(DEPTH));
  assign top_ptr = ptr_q - 1'b1;
  assign top_idx = top_ptr[IW-1:0];
  assign wr_idx  = ptr_q[IW-1:0];
  assign top     = empty ? '0 : mem[top_idx];
  assign ovf     = ovf_q;
  assign unf     = unf_q;

  always_comb begin
    ptr_d = ptr_q;
    if (push && !full)
      ptr_d = ptr_q + 1'b1;
    else if (pop && !empty)
      ptr_d = ptr_q - 1'b1;
    ovf_d = ovf_q | (push & full);
    unf_d = unf_q | (pop & empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // Storage carries no reset; the pointer alone defines validity.
  always_ff @(posedge clk) begin
    if (push && !full)
      mem[wr_idx] <= din;
    else if (wr_top && !empty)
      mem[top_idx] <= din;
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PW'(DEPTH));

  // R10
  full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ($stable(ptr_q) && ovf_q));

  // R11
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |=> unf_q);
endmodule

// File: rtl/zol_next_pc.sv
// Next-address selection and stack command generation.
module zol_next_pc
  import zol_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 16
) (
  input  logic [2:0]    op,
  input  logic          cond,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] pc_top,
  input  logic          pc_empty,
  input  logic [AW-1:0] end_top,
  input  logic          end_empty,
  input  logic [CW-1:0] cnt_top,
  output logic [AW-1:0] pc_nxt,
  output logic          pc_push,
  output logic          pc_pop,
  output logic [AW-1:0] pc_din,
  output logic          end_push,
  output logic          end_pop,
  output logic          cnt_push,
  output logic          cnt_pop,
  output logic          cnt_wr,
  output logic [CW-1:0] cnt_din
);
  logic [AW-1:0] pc_inc;
  logic          at_end, last_pass;
  seq_op_e       op_e;

  assign pc_inc    = pc + 1'b1;
  assign at_end    = !end_empty && (pc == end_top);
  assign last_pass = (cnt_top <= CW'(1));
  assign op_e      = seq_op_e'(op);

  always_comb begin
    pc_nxt   = pc_inc;
    pc_push  = 1'b0;
    pc_pop   = 1'b0;
    pc_din   = pc_inc;
    end_push = 1'b0;
    end_pop  = 1'b0;
    cnt_push = 1'b0;
    cnt_pop  = 1'b0;
    cnt_wr   = 1'b0;
    cnt_din  = count;
    case (op_e)
      OP_JUMP: if (cond) pc_nxt = target;
      OP_CALL: begin
        pc_push = 1'b1;
        pc_nxt  = target;
      end
      OP_RET: begin
        pc_pop = 1'b1;
        if (!pc_empty) pc_nxt = pc_top;
      end
      OP_DO: begin
        pc_push  = 1'b1;
        end_push = 1'b1;
        cnt_push = 1'b1;
      end
      default: begin
        if (at_end) begin
          if (last_pass) begin
            pc_pop  = 1'b1;
            end_pop = 1'b1;
            cnt_pop = 1'b1;
          end else begin
            cnt_wr  = 1'b1;
            cnt_din = cnt_top - 1'b1;
            pc_nxt  = pc_top;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer #(
  parameter int AW         = 12,
  parameter int CW         = 16,
  parameter int PC_DEPTH   = 16,
  parameter int LOOP_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic          cond_i,
  input  logic [AW-1:0] target_i,
  input  logic [CW-1:0] count_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          pc_stk_empty_o,
  output logic          loop_active_o,
  output logic [2:0]    ovf_o,
  output logic [2:0]    unf_o
);
  import zol_pkg::*;

  logic [AW-1:0] fetch_q, fetch_d;
  logic [AW-1:0] pc_top, pc_din, end_top;
  logic [CW-1:0] cnt_top, cnt_din;
  logic          pc_empty, end_empty, cnt_empty;
  logic          pc_push, pc_pop, end_push, end_pop;
  logic          cnt_push, cnt_pop, cnt_wr;
  logic          pc_ovf, end_ovf, cnt_ovf, pc_unf, end_unf, cnt_unf;

  zol_next_pc #(.AW(AW), .CW(CW)) u_next (
    .op(op_i), .cond(cond_i), .target(target_i), .count(count_i),
    .pc(fetch_q), .pc_top(pc_top), .pc_empty(pc_empty),
    .end_top(end_top), .end_empty(end_empty), .cnt_top(cnt_top),
    .pc_nxt(fetch_d), .pc_push(pc_push), .pc_pop(pc_pop), .pc_din(pc_din),
    .end_push(end_push), .end_pop(end_pop),
    .cnt_push(cnt_push), .cnt_pop(cnt_pop), .cnt_wr(cnt_wr), .cnt_din(cnt_din)
  );

  zol_stack #(.W(AW), .DEPTH(PC_DEPTH)) u_pc_stk (
    .clk(clk), .rst_n(rst_n), .push(pc_push), .pop(pc_pop), .wr_top(1'b0),
    .din(pc_din), .top(pc_top), .empty(pc_empty), .ovf(pc_ovf), .unf(pc_unf)
  );

  zol_stack #(.W(AW), .DEPTH(LOOP_DEPTH)) u_end_stk (
    .clk(clk), .rst_n(rst_n), .push(end_push), .pop(end_pop), .wr_top(1'b0),
    .din(target_i), .top(end_top), .empty(end_empty), .ovf(end_ovf), .unf(end_unf)
  );

  zol_stack #(.W(CW), .DEPTH(LOOP_DEPTH)) u_cnt_stk (
    .clk(clk), .rst_n(rst_n), .push(cnt_push), .pop(cnt_pop), .wr_top(cnt_wr),
    .din(cnt_din), .top(cnt_top), .empty(cnt_empty), .ovf(cnt_ovf), .unf(cnt_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_q <= '0;
    else        fetch_q <= fetch_d;
  end

  assign fetch_addr_o   = fetch_q;
  assign pc_stk_empty_o = pc_empty;
  assign loop_active_o  = !end_empty;
  assign ovf_o          = {cnt_ovf, end_ovf, pc_ovf};
  assign unf_o          = {cnt_unf, end_unf, pc_unf};

  // R2
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SEQ && end_empty) |=> fetch_q == $past(fetch_q) + 1'b1);

  // R3
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_JUMP && cond_i) |=> fetch_q == $past(target_i));

  // R4
  call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CALL) |=> (fetch_q == $past(target_i) && !pc_empty));

  // R7
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SEQ && !end_empty && fetch_q == end_top && cnt_top > CW'(1))
      |=> fetch_q == $past(pc_top));

  // R6
  loop_stacks_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_empty == cnt_empty);
endmodule

// File: tb/zol_sequencer_tb.sv
module zol_sequencer_tb;
  localparam int AW = 12;
  localparam int CW = 16;
  localparam int NV = 27;
  localparam int VW = 4 + 3 + 1 + AW + CW + AW;

  // {req, op, cond, target, count, expected fetch}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd1},   // R2 from 0
    {4'd3, 3'd1, 1'b0, 12'd50, 16'd0, 12'd2},   // R3 not taken
    {4'd3, 3'd1, 1'b1, 12'd40, 16'd0, 12'd40},  // R3 taken
    {4'd4, 3'd2, 1'b0, 12'd100,16'd0, 12'd100}, // R4 call from 40
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd101},
    {4'd5, 3'd3, 1'b0, 12'd0,  16'd0, 12'd41},  // R5 return
    {4'd6, 3'd4, 1'b0, 12'd43, 16'd3, 12'd42},  // R6 loop 42..43 x3
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd43},
    {4'd7, 3'd0, 1'b0, 12'd0,  16'd0, 12'd42},  // R7 back
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd43},
    {4'd7, 3'd0, 1'b0, 12'd0,  16'd0, 12'd42},  // R7 back
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd43},
    {4'd8, 3'd0, 1'b0, 12'd0,  16'd0, 12'd44},  // R8 exit
    {4'd6, 3'd4, 1'b0, 12'd49, 16'd2, 12'd45},  // R6 outer 45..49 x2
    {4'd9, 3'd4, 1'b0, 12'd46, 16'd2, 12'd46},  // R9 inner 46..46 x2
    {4'd9, 3'd0, 1'b0, 12'd0,  16'd0, 12'd46},  // R9 inner back
    {4'd8, 3'd0, 1'b0, 12'd0,  16'd0, 12'd47},  // R8 inner exit
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd48},
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd49},
    {4'd9, 3'd0, 1'b0, 12'd0,  16'd0, 12'd45},  // R9 outer back
    {4'd9, 3'd4, 1'b0, 12'd46, 16'd2, 12'd46},
    {4'd9, 3'd0, 1'b0, 12'd0,  16'd0, 12'd46},
    {4'd8, 3'd0, 1'b0, 12'd0,  16'd0, 12'd47},
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd48},
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd49},
    {4'd8, 3'd0, 1'b0, 12'd0,  16'd0, 12'd50},  // R8 outer exit
    {4'd2, 3'd0, 1'b0, 12'd0,  16'd0, 12'd51}
  };

  logic          clk;
  logic          rst_n;
  logic [2:0]    op_i;
  logic          cond_i;
  logic [AW-1:0] target_i;
  logic [CW-1:0] count_i;
  logic [AW-1:0] fetch_addr_o;
  logic          pc_stk_empty_o;
  logic          loop_active_o;
  logic [2:0]    ovf_o;
  logic [2:0]    unf_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  zol_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .cond_i(cond_i),
    .target_i(target_i), .count_i(count_i), .fetch_addr_o(fetch_addr_o),
    .pc_stk_empty_o(pc_stk_empty_o), .loop_active_o(loop_active_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic step(input logic [2:0] op, input logic c,
                      input int tgt, input int cnt);
    op_i     = op;
    cond_i   = c;
    target_i = AW'(tgt);
    count_i  = CW'(cnt);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_i = 3'd0; cond_i = 1'b0; target_i = '0; count_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 fetch", fetch_addr_o, 0);
    check("R1 pc empty", pc_stk_empty_o, 1);
    check("R1 loop active", loop_active_o, 0);
    check("R1 ovf", ovf_o, 0);
    check("R1 unf", unf_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-5 -: 3], v[VW-8], int'(v[2*AW+CW-1 -: AW]),
           int'(v[AW+CW-1 -: CW]));
      check($sformatf("R%0d vector %0d", v[VW-1 -: 4], i),
            fetch_addr_o, int'(v[AW-1:0]));
    end
    // R8 all stacks released after loops exit
    check("R8 loop active after exit", loop_active_o, 0);
    check("R8 pc empty after exit", pc_stk_empty_o, 1);
    check("R8 no flags", {ovf_o, unf_o}, 0);

    // R11 return on empty stack
    do_reset();
    step(3'd3, 1'b0, 0, 0);
    check("R11 fetch", fetch_addr_o, 1);
    check("R11 unf", unf_o, 1);
    step(3'd0, 1'b0, 0, 0);
    check("R11 unf sticky", unf_o, 1);

    // R10 return stack depth
    do_reset();
    for (int k = 0; k < 16; k++) step(3'd2, 1'b0, 200 + k, 0);
    check("R10 no ovf at 16", ovf_o, 0);
    step(3'd2, 1'b0, 216, 0);
    check("R10 ovf at 17", ovf_o, 1);
    check("R10 call still redirects", fetch_addr_o, 216);
    for (int k = 0; k < 16; k++) step(3'd3, 1'b0, 0, 0);
    check("R10 deepest entry", fetch_addr_o, 1);
    check("R10 no unf yet", unf_o, 0);
    step(3'd3, 1'b0, 0, 0);
    check("R11 unf after drain", unf_o, 1);
    check("R11 fall through", fetch_addr_o, 2);

    // R12 loop stack depth
    do_reset();
    for (int k = 0; k < 4; k++) step(3'd4, 1'b0, 300, 5);
    check("R12 no ovf at 4", ovf_o, 0);
    step(3'd4, 1'b0, 300, 5);
    check("R12 ovf at 5", ovf_o, 6);
    check("R12 fetch", fetch_addr_o, 5);

    // R7 non-sequential instruction at loop end takes its own path
    do_reset();
    step(3'd4, 1'b0, 2, 3);       // loop 1..2
    step(3'd0, 1'b0, 0, 0);       // fetch 2
    step(3'd1, 1'b1, 90, 0);      // jump at loop end
    check("R7 jump wins at loop end", fetch_addr_o, 90);
    check("R7 loop still open", loop_active_o, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule